// File: doc/BRIEF.md
# Profiling Filter Register Access Gate

This block decides what happens when software tries to read or write one particular privileged profiling-filter system register. Each request carries the instruction's register-select encoding, its direction and the privilege level it comes from (0 to 3). Alongside the request the block reads the control state that governs that register: which optional features exist, the level-3 enable and ownership bits, the level-2 trap bits, the fine-grained trap controls and the nested-virtualization mode. From these it picks exactly one outcome through a fixed priority chain.

The outcome is registered and appears one clock after the request strobe. There are five outcomes, encoded one-hot: ordinary register access, undefined instruction, trap to level 2, trap to level 3, and redirection of the access to a fixed offset in the hypervisor's memory page. Both traps report a syndrome class, and the redirect reports its offset. A request whose encoding selects some other register produces no result. The block does not hold the register, enter the exception or perform the memory access.

Top module: `preg_access_chk`

## Requirements
- R1: A matching request from level 0 always gives the undefined outcome.
- R2: A matching request from level 3 always gives the ordinary access outcome, whatever the control inputs are.
- R3: Ownership fails when own_bits[0] is 0, when own_bits[1] differs from cur_ns, or when the realm feature is present and own_ext differs from cur_nse. A failed ownership check at level 1, with no higher-priority condition, gives a trap to level 3.
- R4: At level 1, with level 3 present and undef_prio set, a cleared l3_prof_en and then a failed ownership check each give undefined, ahead of every trap condition.
- R5: At level 1, when level 2 is enabled and the fine-grained trap feature is present, the request traps to level 2 if level 3 is present with l3_fgt_en at 0, or if the active-low fine-grained bit for its direction is 0 (fg_rd_n for reads, fg_wr_n for writes). The other direction's bit has no effect.
- R6: At level 1, when level 2 is enabled and l2_prof_trap is 1, the request traps to level 2. This ranks below R5 and above every level-3 trap.
- R7: At level 1 and below the R5 and R6 checks, with level 3 present, a cleared l3_prof_en and then a failed ownership check each give undefined when sdd_undef is 1 and otherwise a trap to level 3. Without level 3 these checks do not apply.
- R8: At level 1, when no earlier condition applies and nv_mode matches the pattern 1x1 (bits 2 and 0 set), the access is redirected to memory offset 0x858. Any other nv_mode gives ordinary access.
- R9: At level 2, only the level-3 checks apply, ownership first and the enable second. With undef_prio set either failure gives undefined; otherwise it gives undefined when sdd_undef is 1 and a trap to level 3 when it is 0. The level-2 trap bits, the fine-grained bits and nv_mode have no effect, and with no failure the result is ordinary access.
- R10: Only the encoding op0=0b11, op1=0b000, CRn=0b1001, CRm=0b1010, op2=0b100 with req_valid high produces a result. Any other request leaves res_valid low, with res_kind, res_class and res_offset all zero, in the following cycle.
- R11: One cycle after a matching request, res_valid is 1 and res_kind has exactly one bit set: bit 0 ordinary, bit 1 undefined, bit 2 trap to level 2, bit 3 trap to level 3, bit 4 redirect. res_class is 0x18 on either trap and 0 otherwise. res_offset is 0x858 on a redirect and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_is_write | input | 1 | 1 for a write, 0 for a read |
| cur_level | input | 2 | Privilege level of the requester |
| has_l3 | input | 1 | Level 3 is implemented |
| has_realm | input | 1 | Realm feature is present |
| has_fgt | input | 1 | Second fine-grained trap feature is present |
| l2_enabled | input | 1 | Level 2 is enabled in the current state |
| undef_prio | input | 1 | Level-3 undefined-takes-priority mode |
| sdd_undef | input | 1 | Level-3 failures give undefined instead of a trap |
| l3_prof_en | input | 1 | Level-3 enable for profiling-register access |
| own_bits | input | 2 | Profiling-buffer ownership bits |
| own_ext | input | 1 | Extended ownership bit |
| cur_ns | input | 1 | Current non-secure bit |
| cur_nse | input | 1 | Current extended security bit |
| l3_fgt_en | input | 1 | Level-3 enable for the fine-grained trap controls |
| fg_rd_n | input | 1 | Active-low fine-grained trap bit for reads |
| fg_wr_n | input | 1 | Active-low fine-grained trap bit for writes |
| l2_prof_trap | input | 1 | Level-2 profiling-register trap bit |
| nv_mode | input | 3 | Nested-virtualization mode field |
| res_valid | output | 1 | Result valid, one cycle after a matching request |
| res_kind | output | 5 | One-hot outcome |
| res_class | output | 6 | Syndrome class on a trap |
| res_offset | output | 12 | Memory offset on a redirect |

## Verification
On every cycle the assertions check the result timing and its shape: one-hot outcome after a matching request, nothing after any other request, level 0 always undefined and level 3 always ordinary, the syndrome class tied to the trap bits and the offset tied to the redirect bit. Which outcome wins at levels 1 and 2 when several conditions hold at once only the bench shows. Its scenarios stack conditions in pairs to expose the ranking, swap the read and write fine-grained bits, toggle the realm feature under the ownership check, and sweep random control states against a model built from the requirements.

// File: rtl/preg_access_pkg.sv
package preg_access_pkg;

   // one-hot outcome bit positions
   localparam int RK_NORMAL  = 0;
   localparam int RK_UNDEF   = 1;
   localparam int RK_TRAP_L2 = 2;
   localparam int RK_TRAP_L3 = 3;
   localparam int RK_REDIR   = 4;
   localparam int RK_W       = 5;

   typedef logic [RK_W-1:0] kind_t;

   typedef enum logic [1:0] {
      LVL_0 = 2'd0,
      LVL_1 = 2'd1,
      LVL_2 = 2'd2,
      LVL_3 = 2'd3
   } lvl_e;

   function automatic kind_t kind_bit(int idx);
      kind_t k;
      k = '0;
      k[idx] = 1'b1;
      return k;
   endfunction

endpackage

// File: rtl/preg_enc_match.sv
module preg_enc_match #(
   parameter logic [1:0] MATCH_OP0 = 2'b11,
   parameter logic [2:0] MATCH_OP1 = 3'b000,
   parameter logic [3:0] MATCH_CRN = 4'b1001,
   parameter logic [3:0] MATCH_CRM = 4'b1010,
   parameter logic [2:0] MATCH_OP2 = 3'b100
) (
   input  logic [1:0] op0,
   input  logic [2:0] op1,
   input  logic [3:0] crn,
   input  logic [3:0] crm,
   input  logic [2:0] op2,
   output logic       hit
);
   localparam int ENC_W = 2 + 3 + 4 + 4 + 3;
   localparam logic [ENC_W-1:0] ENC_KEY = {MATCH_OP0, MATCH_OP1, MATCH_CRN, MATCH_CRM, MATCH_OP2};

   logic [ENC_W-1:0] enc;
   assign enc = {op0, op1, crn, crm, op2};
   assign hit = (enc == ENC_KEY);
endmodule

// File: rtl/preg_own_chk.sv
module preg_own_chk (
   input  logic [1:0] own_bits,
   input  logic       own_ext,
   input  logic       cur_ns,
   input  logic       cur_nse,
   input  logic       has_realm,
   output logic       own_fail
);
   logic base_fail, ns_fail, realm_fail;
   assign base_fail  = ~own_bits[0];
   assign ns_fail    = own_bits[1] ^ cur_ns;
   assign realm_fail = has_realm & (own_ext ^ cur_nse);
   assign own_fail   = base_fail | ns_fail | realm_fail;
endmodule

// File: rtl/preg_prio.sv
module preg_prio
   import preg_access_pkg::*;
#(
   parameter bit         NV_REDIRECT_EN = 1'b1,
   parameter logic [2:0] NV_MASK        = 3'b101,
   parameter logic [2:0] NV_VALUE       = 3'b101
) (
   input  logic [1:0] cur_level,
   input  logic       is_write,
   input  logic       has_l3,
   input  logic       has_fgt,
   input  logic       l2_enabled,
   input  logic       undef_prio,
   input  logic       sdd_undef,
   input  logic       l3_prof_en,
   input  logic       own_fail,
   input  logic       l3_fgt_en,
   input  logic       fg_rd_n,
   input  logic       fg_wr_n,
   input  logic       l2_prof_trap,
   input  logic [2:0] nv_mode,
   output kind_t      kind
);
   if ((NV_VALUE & ~NV_MASK) != 3'b000) begin : g_bad_nv
      $error("NV_VALUE has bits outside NV_MASK");
   end

   logic nv_hit;
   if (NV_REDIRECT_EN) begin : g_nv_on
      assign nv_hit = ((nv_mode & NV_MASK) == NV_VALUE);
   end else begin : g_nv_off
      assign nv_hit = 1'b0;
   end

   logic en_off, prio_mode, fg_bit_n, fg_trap, l2_trap, l3_fail_kind_undef;
   assign en_off    = has_l3 & ~l3_prof_en;
   assign prio_mode = has_l3 & undef_prio;
   assign fg_bit_n  = is_write ? fg_wr_n : fg_rd_n;
   assign fg_trap   = l2_enabled & has_fgt & ((has_l3 & ~l3_fgt_en) | ~fg_bit_n);
   assign l2_trap   = l2_enabled & l2_prof_trap;
   assign l3_fail_kind_undef = sdd_undef;

   kind_t l3_late;
   assign l3_late = l3_fail_kind_undef ? kind_bit(RK_UNDEF) : kind_bit(RK_TRAP_L3);

   logic own_fail_l3;
   assign own_fail_l3 = has_l3 & own_fail;

   always_comb begin
      kind = kind_bit(RK_NORMAL);
      unique case (lvl_e'(cur_level))
         LVL_0: kind = kind_bit(RK_UNDEF);
         LVL_1: begin
            if (prio_mode & ~l3_prof_en)   kind = kind_bit(RK_UNDEF);
            else if (prio_mode & own_fail) kind = kind_bit(RK_UNDEF);
            else if (fg_trap)              kind = kind_bit(RK_TRAP_L2);
            else if (l2_trap)              kind = kind_bit(RK_TRAP_L2);
            else if (en_off)               kind = l3_late;
            else if (own_fail_l3)          kind = l3_late;
            else if (nv_hit)               kind = kind_bit(RK_REDIR);
            else                           kind = kind_bit(RK_NORMAL);
         end
         LVL_2: begin
            if (prio_mode & own_fail)        kind = kind_bit(RK_UNDEF);
            else if (prio_mode & ~l3_prof_en) kind = kind_bit(RK_UNDEF);
            else if (own_fail_l3)            kind = l3_late;
            else if (en_off)                 kind = l3_late;
            else                             kind = kind_bit(RK_NORMAL);
         end
         LVL_3: kind = kind_bit(RK_NORMAL);
         default: kind = kind_bit(RK_UNDEF);
      endcase
   end
endmodule

// File: rtl/preg_access_chk.sv
module preg_access_chk
   import preg_access_pkg::*;
#(
   parameter int          CLASS_W    = 6,
   parameter int          OFFSET_W   = 12,
   parameter logic [11:0] NV_OFFSET  = 12'h858,
   parameter logic [5:0]  TRAP_CLASS = 6'h18
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [1:0]          req_op0,
   input  logic [2:0]          req_op1,
   input  logic [3:0]          req_crn,
   input  logic [3:0]          req_crm,
   input  logic [2:0]          req_op2,
   input  logic                req_is_write,
   input  logic [1:0]          cur_level,
   input  logic                has_l3,
   input  logic                has_realm,
   input  logic                has_fgt,
   input  logic                l2_enabled,
   input  logic                undef_prio,
   input  logic                sdd_undef,
   input  logic                l3_prof_en,
   input  logic [1:0]          own_bits,
   input  logic                own_ext,
   input  logic                cur_ns,
   input  logic                cur_nse,
   input  logic                l3_fgt_en,
   input  logic                fg_rd_n,
   input  logic                fg_wr_n,
   input  logic                l2_prof_trap,
   input  logic [2:0]          nv_mode,
   output logic                res_valid,
   output logic [RK_W-1:0]     res_kind,
   output logic [CLASS_W-1:0]  res_class,
   output logic [OFFSET_W-1:0] res_offset
);
   if (CLASS_W < 6) begin : g_bad_class
      $error("CLASS_W too narrow for the syndrome class");
   end
   if (OFFSET_W < 12) begin : g_bad_off
      $error("OFFSET_W too narrow for the redirect offset");
   end

   localparam logic [CLASS_W-1:0]  CLASS_VAL  = CLASS_W'(TRAP_CLASS);
   localparam logic [OFFSET_W-1:0] OFFSET_VAL = OFFSET_W'(NV_OFFSET);

   logic  hit, fire, own_fail;
   kind_t kind_d;

   preg_enc_match u_match (
      .op0(req_op0), .op1(req_op1), .crn(req_crn), .crm(req_crm), .op2(req_op2),
      .hit(hit)
   );

   preg_own_chk u_own (
      .own_bits(own_bits), .own_ext(own_ext), .cur_ns(cur_ns), .cur_nse(cur_nse),
      .has_realm(has_realm), .own_fail(own_fail)
   );

   preg_prio u_prio (
      .cur_level(cur_level), .is_write(req_is_write), .has_l3(has_l3), .has_fgt(has_fgt),
      .l2_enabled(l2_enabled), .undef_prio(undef_prio), .sdd_undef(sdd_undef),
      .l3_prof_en(l3_prof_en), .own_fail(own_fail), .l3_fgt_en(l3_fgt_en),
      .fg_rd_n(fg_rd_n), .fg_wr_n(fg_wr_n), .l2_prof_trap(l2_prof_trap),
      .nv_mode(nv_mode), .kind(kind_d)
   );

   assign fire = req_valid & hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_kind   <= '0;
         res_class  <= '0;
         res_offset <= '0;
      end else begin
         res_valid  <= fire;
         res_kind   <= fire ? kind_d : '0;
         res_class  <= (fire & (kind_d[RK_TRAP_L2] | kind_d[RK_TRAP_L3])) ? CLASS_VAL : '0;
         res_offset <= (fire & kind_d[RK_REDIR]) ? OFFSET_VAL : '0;
      end
   end

   a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> ($countones(res_kind) == 1));
   a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && hit) |=> (!res_valid && res_kind == '0));
   a_r1_level0: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && hit && cur_level == 2'd0) |=> res_kind[RK_UNDEF]);
   a_r2_level3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && hit && cur_level == 2'd3) |=> res_kind[RK_NORMAL]);
   a_r11_class: assert property (@(posedge clk) disable iff (!rst_n)
      (res_kind[RK_TRAP_L2] || res_kind[RK_TRAP_L3]) == (res_class == CLASS_VAL));
   a_r8_offset: assert property (@(posedge clk) disable iff (!rst_n)
      res_kind[RK_REDIR] == (res_offset == OFFSET_VAL));
   a_r9_level2_no_l2trap: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && hit && cur_level == 2'd2) |=> !(res_kind[RK_TRAP_L2] || res_kind[RK_REDIR]));
endmodule

// File: tb/sim_preg_access_chk.sv
module sim_preg_access_chk;
   typedef struct packed {
      logic       valid;
      logic [1:0] op0;
      logic [2:0] op1;
      logic [3:0] crn;
      logic [3:0] crm;
      logic [2:0] op2;
      logic       wr;
      logic [1:0] lvl;
      logic       has_l3, has_realm, has_fgt, l2_on, uprio, sdd, l3_en;
      logic [1:0] own;
      logic       own_ext, ns, nse, fgt_en, fg_rd_n, fg_wr_n, prof_trap;
      logic [2:0] nv;
   } stim_t;

   typedef struct {
      int         stamp;
      logic       valid;
      logic [4:0] kind;
      logic [5:0] cls;
      logic [11:0] off;
      string      tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   stim_t s;
   exp_t  q[$];
   int    cyc = 0;
   int    total = 0;
   int    bad = 0;
   bit    done = 1'b0;

   logic        res_valid;
   logic [4:0]  res_kind;
   logic [5:0]  res_class;
   logic [11:0] res_offset;

   preg_access_chk u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(s.valid),
      .req_op0(s.op0), .req_op1(s.op1), .req_crn(s.crn), .req_crm(s.crm), .req_op2(s.op2),
      .req_is_write(s.wr), .cur_level(s.lvl), .has_l3(s.has_l3), .has_realm(s.has_realm),
      .has_fgt(s.has_fgt), .l2_enabled(s.l2_on), .undef_prio(s.uprio), .sdd_undef(s.sdd),
      .l3_prof_en(s.l3_en), .own_bits(s.own), .own_ext(s.own_ext), .cur_ns(s.ns),
      .cur_nse(s.nse), .l3_fgt_en(s.fgt_en), .fg_rd_n(s.fg_rd_n), .fg_wr_n(s.fg_wr_n),
      .l2_prof_trap(s.prof_trap), .nv_mode(s.nv),
      .res_valid(res_valid), .res_kind(res_kind), .res_class(res_class), .res_offset(res_offset)
   );

   always @(posedge clk) cyc <= cyc + 1;

   // expected outcome from the requirements; bits: 0 normal, 1 undef, 2 trap2, 3 trap3, 4 redirect
   function automatic logic [4:0] model(stim_t t);
      logic ofail, late_undef;
      ofail = !t.own[0] || (t.own[1] != t.ns) || (t.has_realm && (t.own_ext != t.nse));
      late_undef = t.sdd;
      case (t.lvl)
         2'd0: return 5'b00010;
         2'd3: return 5'b00001;
         2'd1: begin
            if (t.has_l3 && t.uprio && !t.l3_en) return 5'b00010;
            if (t.has_l3 && t.uprio && ofail) return 5'b00010;
            if (t.l2_on && t.has_fgt &&
                ((t.has_l3 && !t.fgt_en) || !(t.wr ? t.fg_wr_n : t.fg_rd_n))) return 5'b00100;
            if (t.l2_on && t.prof_trap) return 5'b00100;
            if (t.has_l3 && !t.l3_en) return late_undef ? 5'b00010 : 5'b01000;
            if (t.has_l3 && ofail) return late_undef ? 5'b00010 : 5'b01000;
            if (t.nv[2] && t.nv[0]) return 5'b10000;
            return 5'b00001;
         end
         default: begin
            if (t.has_l3 && t.uprio && (ofail || !t.l3_en)) return 5'b00010;
            if (t.has_l3 && (ofail || !t.l3_en)) return late_undef ? 5'b00010 : 5'b01000;
            return 5'b00001;
         end
      endcase
   endfunction

   function automatic stim_t base();
      stim_t t;
      t = '0;
      t.valid = 1'b1; t.op0 = 2'b11; t.op1 = 3'b000; t.crn = 4'b1001; t.crm = 4'b1010; t.op2 = 3'b100;
      t.lvl = 2'd1; t.has_l3 = 1; t.has_realm = 1; t.has_fgt = 1; t.l2_on = 1;
      t.l3_en = 1; t.own = 2'b11; t.ns = 1; t.fgt_en = 1; t.fg_rd_n = 1; t.fg_wr_n = 1;
      return t;
   endfunction

   // driver: apply one request for one cycle and queue its expected result
   task automatic go(stim_t t, string tag);
      exp_t e;
      logic hit;
      s = t;
      hit = t.valid && t.op0 == 2'b11 && t.op1 == 3'b000 && t.crn == 4'b1001 &&
            t.crm == 4'b1010 && t.op2 == 3'b100;
      e.stamp = cyc;
      e.valid = hit;
      e.kind  = hit ? model(t) : 5'b0;
      e.cls   = (e.kind[2] || e.kind[3]) ? 6'h18 : 6'h0;
      e.off   = e.kind[4] ? 12'h858 : 12'h0;
      e.tag   = tag;
      q.push_back(e);
      @(negedge clk);
   endtask

   // monitor: compare at the falling edge after the capturing rising edge
   always @(negedge clk) begin
      if (q.size() > 0 && q[0].stamp + 1 == cyc) begin
         exp_t e;
         e = q.pop_front();
         total++;
         if (res_valid !== e.valid || res_kind !== e.kind || res_class !== e.cls || res_offset !== e.off) begin
            bad++;
            $display("FAIL %s: got v=%b k=%b c=%h o=%h, want v=%b k=%b c=%h o=%h", e.tag,
                     res_valid, res_kind, res_class, res_offset, e.valid, e.kind, e.cls, e.off);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got hung run, want completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      stim_t t;
      s = base();
      s.valid = 1'b0;
      repeat (3) @(negedge clk);
      total++;
      if (res_valid !== 1'b0 || res_kind !== 5'b0) begin
         bad++;
         $display("FAIL reset R11: got v=%b k=%b, want v=0 k=00000", res_valid, res_kind);
      end
      rst_n = 1'b1;
      @(negedge clk);

      go(base(), "R8 clean level1 normal");
      t = base(); t.lvl = 2'd0;                               go(t, "R1 level0 undef");
      t = base(); t.lvl = 2'd3; t.own = 0; t.l3_en = 0; t.prof_trap = 1; t.nv = 3'b101;
                                                              go(t, "R2 level3 normal");
      t = base(); t.own[0] = 0;                               go(t, "R3 own bit0 trap3");
      t = base(); t.own[1] = 0;                               go(t, "R3 own ns mismatch trap3");
      t = base(); t.nse = 1;                                  go(t, "R3 realm mismatch trap3");
      t = base(); t.nse = 1; t.has_realm = 0;                 go(t, "R3 realm absent normal");
      t = base(); t.uprio = 1; t.l3_en = 0; t.prof_trap = 1;  go(t, "R4 enable off undef first");
      t = base(); t.uprio = 1; t.own[0] = 0; t.fg_rd_n = 0;   go(t, "R4 own fail undef first");
      t = base(); t.uprio = 1; t.has_l3 = 0; t.l3_en = 0;     go(t, "R4 no level3 normal");
      t = base(); t.fg_rd_n = 0;                              go(t, "R5 read bit traps");
      t = base(); t.fg_rd_n = 0; t.wr = 1;                    go(t, "R5 read bit ignored on write");
      t = base(); t.fg_wr_n = 0; t.wr = 1;                    go(t, "R5 write bit traps");
      t = base(); t.fg_wr_n = 0;                              go(t, "R5 write bit ignored on read");
      t = base(); t.fgt_en = 0;                               go(t, "R5 level3 fg enable traps");
      t = base(); t.fg_rd_n = 0; t.has_fgt = 0;               go(t, "R5 feature absent normal");
      t = base(); t.fg_rd_n = 0; t.l2_on = 0;                 go(t, "R5 level2 off normal");
      t = base(); t.fg_rd_n = 0; t.l3_en = 0;                 go(t, "R5 fg ahead of level3");
      t = base(); t.prof_trap = 1; t.l3_en = 0; t.sdd = 1;    go(t, "R6 l2 trap ahead of level3");
      t = base(); t.prof_trap = 1; t.l2_on = 0;               go(t, "R6 level2 off normal");
      t = base(); t.l3_en = 0;                                go(t, "R7 enable off trap3");
      t = base(); t.l3_en = 0; t.sdd = 1;                     go(t, "R7 enable off sdd undef");
      t = base(); t.own[0] = 0; t.sdd = 1;                    go(t, "R7 own fail sdd undef");
      t = base(); t.has_l3 = 0; t.l3_en = 0; t.own = 0;       go(t, "R7 no level3 normal");
      t = base(); t.nv = 3'b101;                              go(t, "R8 nv 101 redirect");
      t = base(); t.nv = 3'b111;                              go(t, "R8 nv 111 redirect");
      t = base(); t.nv = 3'b100;                              go(t, "R8 nv 100 normal");
      t = base(); t.nv = 3'b001;                              go(t, "R8 nv 001 normal");
      t = base(); t.nv = 3'b101; t.prof_trap = 1;             go(t, "R8 trap beats redirect");
      t = base(); t.lvl = 2'd2;                               go(t, "R9 level2 normal");
      t = base(); t.lvl = 2'd2; t.own[0] = 0;                 go(t, "R9 level2 own trap3");
      t = base(); t.lvl = 2'd2; t.own[0] = 0; t.uprio = 1;    go(t, "R9 level2 prio undef");
      t = base(); t.lvl = 2'd2; t.l3_en = 0; t.uprio = 1;     go(t, "R9 level2 enable undef");
      t = base(); t.lvl = 2'd2; t.l3_en = 0; t.sdd = 1;       go(t, "R9 level2 sdd undef");
      t = base(); t.lvl = 2'd2; t.prof_trap = 1; t.fg_rd_n = 0; t.fgt_en = 0; t.nv = 3'b101;
                                                              go(t, "R9 level2 ignores l2 bits");
      t = base(); t.crm = 4'b1011;                            go(t, "R10 other CRm");
      t = base(); t.op2 = 3'b000;                             go(t, "R10 other op2");
      t = base(); t.valid = 0;                                go(t, "R10 no strobe");
      go(base(), "R11 back to back");
      t = base(); t.fg_rd_n = 0;                              go(t, "R11 trap class");

      for (int i = 0; i < 400; i++) begin
         t = base();
         t.wr = 1'($urandom); t.lvl = 2'($urandom);
         t.has_l3 = 1'($urandom); t.has_realm = 1'($urandom); t.has_fgt = 1'($urandom);
         t.l2_on = 1'($urandom); t.uprio = 1'($urandom); t.sdd = 1'($urandom);
         t.l3_en = ($urandom % 4) != 0; t.own = 2'($urandom); t.own_ext = 1'($urandom);
         t.ns = 1'($urandom); t.nse = 1'($urandom); t.fgt_en = ($urandom % 4) != 0;
         t.fg_rd_n = ($urandom % 4) != 0; t.fg_wr_n = ($urandom % 4) != 0;
         t.prof_trap = ($urandom % 4) == 0; t.nv = 3'($urandom);
         if ($urandom % 10 == 0) t.crn = 4'($urandom);
         t.valid = ($urandom % 8) != 0;
         go(t, "R11 random sweep");
      end

      s.valid = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule